// File: doc/BRIEF.md
# Serial Presence Detect Target

This block is a two-wire serial target that stands in for the small identification store found on a memory module. It holds 256 bytes, loaded at reset from a parameter image, and answers on the bus at a seven-bit device address whose upper four bits are a parameter (default `1010`) and whose lower three bits come from strap inputs. A host first sends a word address and then writes bytes into the store. It can also use a repeated start to read any byte, then keep clocking to read the bytes that follow.

SCL and SDA are sampled in the system clock domain through a short synchronizer. The block only pulls SDA low, through an open-drain enable. It never drives the line high. After a stop that ends a transaction in which at least one data byte was written, the block models the store's internal programming time. For a parameterised number of clock cycles it releases SDA and does not acknowledge its own address.

Top module: `spd_i2c_target`

## Requirements
- R1: The address byte is acknowledged only when its upper seven bits equal `1010` followed by `strap_i[2:0]`, with `strap_i[2]` as the more significant bit. Any other address leaves SDA released for the acknowledge bit and for the rest of the transaction.
- R2: In a write transaction (address bit 0 = 0), the first byte after the address sets the word address. Each later complete byte is stored at the word address and acknowledged, and the word address then increments.
- R3: A random read is done as follows: address with bit 0 = 0, then a word address byte, then a repeated start, then address with bit 0 = 1. It returns the stored byte at that word address, most significant bit first.
- R4: During a read, a master acknowledge (SDA low on the ninth clock) advances to the next byte. A master not-acknowledge releases SDA for all following clocks and leaves the word address on the byte just read, so a later read with no word address returns that same byte.
- R5: A stop that ends a transaction containing at least one stored data byte starts a write cycle of `WR_CYCLES` clocks, during which the address is not acknowledged. A stop after only a word address starts no write cycle.
- R6: After reset the store holds the default image. Byte i for i < 63 is (7*i+3) mod 256. Byte 63 is the mod-256 sum of bytes 0..62. Byte i for 64 ≤ i < 128 is i XOR A5h. Bytes 128..255 are FFh.
- R7: A stop or start that arrives before the eighth bit of a data byte discards the partial byte, and the store keeps its old contents.
- R8: After reset `sda_oe_o` is 0.
- R9: The word address wraps from 255 to 0, both in sequential writes and in sequential reads.
- R10: `sda_oe_o` changes only while the synchronized SCL is low, or on a start or a stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; reloads the image |
| strap_i | input | 3 | Low three bits of the device address |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| sda_oe_o | output | 1 | When 1, the block pulls SDA low |

## Verification
The hardest state to reach is the write-cycle window. It needs a write transaction with at least one complete data byte, closed by a stop, and then a new address phase that begins before the timer expires. The bench issues that address immediately after the stop and expects a not-acknowledge. It then waits past the window and reads the written bytes back across the 255-to-0 wrap. It also closes two other transactions with a stop: one that carried only a word address, and one cut short inside a data byte. After each, it shows that the address is acknowledged at once and that the store is unchanged.

// File: rtl/spd_pkg.sv
package spd_pkg;

    localparam int SPD_BYTES = 256;
    localparam int WA_W      = 8;

    typedef logic [SPD_BYTES-1:0][7:0] spd_image_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEVADDR,
        ST_WORDADDR,
        ST_WRDATA,
        ST_ACKSLOT,
        ST_RDBITS,
        ST_RDACK,
        ST_RDNEXT
    } spd_state_e;

    typedef enum logic [1:0] {
        NX_WORDADDR,
        NX_WRDATA,
        NX_RDBYTE
    } spd_next_e;

    typedef struct packed {
        logic scl;
        logic sda;
        logic rise;
        logic fall;
        logic start;
        logic stop;
    } line_evt_t;

    function automatic spd_image_t default_image();
        spd_image_t img;
        logic [7:0] sum;
        sum = '0;
        for (int i = 0; i < SPD_BYTES; i++) begin
            if (i < 63) begin
                img[i] = 8'(7 * i + 3);
                sum    = sum + img[i];
            end else if (i == 63) begin
                img[i] = sum;
            end else if (i < 128) begin
                img[i] = 8'(i) ^ 8'hA5;
            end else begin
                img[i] = 8'hFF;
            end
        end
        return img;
    endfunction

    function automatic logic [6:0] dev_address(logic [3:0] prefix, logic [2:0] strap);
        return {prefix, strap};
    endfunction

endpackage

// File: rtl/spd_line_sync.sv
module spd_line_sync
    import spd_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      scl_i,
    input  logic      sda_i,
    output line_evt_t evt
);
    logic [SYNC_STAGES:0] scl_p;
    logic [SYNC_STAGES:0] sda_p;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_p <= '1;
            sda_p <= '1;
        end else begin
            scl_p <= {scl_p[SYNC_STAGES-1:0], scl_i};
            sda_p <= {sda_p[SYNC_STAGES-1:0], sda_i};
        end
    end

    logic scl_now, scl_old, sda_now, sda_old;
    assign scl_now = scl_p[SYNC_STAGES-1];
    assign scl_old = scl_p[SYNC_STAGES];
    assign sda_now = sda_p[SYNC_STAGES-1];
    assign sda_old = sda_p[SYNC_STAGES];

    always_comb begin
        evt.scl   = scl_now;
        evt.sda   = sda_now;
        evt.rise  = scl_now & ~scl_old;
        evt.fall  = ~scl_now & scl_old;
        evt.start = scl_now & scl_old & sda_old & ~sda_now;
        evt.stop  = scl_now & scl_old & ~sda_old & sda_now;
    end
endmodule

// File: rtl/spd_store.sv
module spd_store
    import spd_pkg::*;
#(
    parameter spd_image_t INIT = spd_pkg::default_image()
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            we,
    input  logic [WA_W-1:0] addr,
    input  logic [7:0]      wdata,
    output logic [7:0]      rdata
);
    logic [7:0] mem [SPD_BYTES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < SPD_BYTES; i++) mem[i] <= INIT[i];
        end else if (we) begin
            mem[addr] <= wdata;
        end
    end

    assign rdata = mem[addr];

    assert_write_lands_R2: assert property (@(posedge clk) disable iff (rst)
        we |=> mem[$past(addr)] == $past(wdata));
endmodule

// File: rtl/spd_busy_timer.sv
module spd_busy_timer #(
    parameter int CYCLES = 1500000
) (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    output logic busy
);
    localparam int CNT_W = $clog2(CYCLES + 1);

    logic [CNT_W-1:0] count;

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (arm) begin
            count <= CNT_W'(CYCLES);
        end else if (count != '0) begin
            count <= count - 1'b1;
        end
    end

    assign busy = (count != '0);
endmodule

// File: rtl/spd_i2c_target.sv
module spd_i2c_target
    import spd_pkg::*;
#(
    parameter logic [3:0] DEV_PREFIX  = 4'b1010,
    parameter int         WR_CYCLES   = 1500000,
    parameter int         SYNC_STAGES = 2,
    parameter spd_image_t INIT_IMAGE  = spd_pkg::default_image()
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] strap_i,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe_o
);
    line_evt_t       evt;
    spd_state_e      state;
    spd_next_e       nxt;
    logic [2:0]      bit_cnt;
    logic            got8;
    logic [7:0]      shreg;
    logic [7:0]      tx;
    logic [WA_W-1:0] word_addr;
    logic            wrote;
    logic            sda_oe;
    logic            busy;
    logic            store_we;
    logic            arm;
    logic [7:0]      rdata;
    logic [6:0]      my_addr;

    spd_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .evt   (evt)
    );

    spd_store #(.INIT(INIT_IMAGE)) u_store (
        .clk   (clk),
        .rst   (rst),
        .we    (store_we),
        .addr  (word_addr),
        .wdata (shreg),
        .rdata (rdata)
    );

    spd_busy_timer #(.CYCLES(WR_CYCLES)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .arm  (arm),
        .busy (busy)
    );

    assign my_addr  = dev_address(DEV_PREFIX, strap_i);
    assign store_we = (state == ST_WRDATA) && evt.fall && got8;
    assign arm      = evt.stop && wrote;
    assign sda_oe_o = sda_oe;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            nxt       <= NX_WORDADDR;
            bit_cnt   <= '0;
            got8      <= 1'b0;
            shreg     <= '0;
            tx        <= '0;
            word_addr <= '0;
            wrote     <= 1'b0;
            sda_oe    <= 1'b0;
        end else if (evt.start) begin
            state   <= ST_DEVADDR;
            bit_cnt <= '0;
            got8    <= 1'b0;
            sda_oe  <= 1'b0;
        end else if (evt.stop) begin
            state  <= ST_IDLE;
            got8   <= 1'b0;
            sda_oe <= 1'b0;
            wrote  <= 1'b0;
        end else begin
            unique case (state)
                ST_DEVADDR, ST_WORDADDR, ST_WRDATA: begin
                    if (evt.rise && !got8) begin
                        shreg   <= {shreg[6:0], evt.sda};
                        bit_cnt <= bit_cnt + 1'b1;
                        if (bit_cnt == 3'd7) got8 <= 1'b1;
                    end else if (evt.fall && got8) begin
                        got8 <= 1'b0;
                        if (state == ST_DEVADDR) begin
                            if (shreg[7:1] == my_addr && !busy) begin
                                sda_oe <= 1'b1;
                                state  <= ST_ACKSLOT;
                                nxt    <= shreg[0] ? NX_RDBYTE : NX_WORDADDR;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end else if (state == ST_WORDADDR) begin
                            word_addr <= shreg;
                            sda_oe    <= 1'b1;
                            state     <= ST_ACKSLOT;
                            nxt       <= NX_WRDATA;
                        end else begin
                            word_addr <= word_addr + 1'b1;
                            wrote     <= 1'b1;
                            sda_oe    <= 1'b1;
                            state     <= ST_ACKSLOT;
                            nxt       <= NX_WRDATA;
                        end
                    end
                end
                ST_ACKSLOT: begin
                    if (evt.fall) begin
                        bit_cnt <= '0;
                        unique case (nxt)
                            NX_WORDADDR: begin
                                sda_oe <= 1'b0;
                                state  <= ST_WORDADDR;
                            end
                            NX_WRDATA: begin
                                sda_oe <= 1'b0;
                                state  <= ST_WRDATA;
                            end
                            default: begin
                                tx     <= rdata;
                                sda_oe <= ~rdata[7];
                                state  <= ST_RDBITS;
                            end
                        endcase
                    end
                end
                ST_RDBITS: begin
                    if (evt.fall) begin
                        if (bit_cnt == 3'd7) begin
                            sda_oe <= 1'b0;
                            state  <= ST_RDACK;
                        end else begin
                            tx      <= {tx[6:0], 1'b0};
                            sda_oe  <= ~tx[6];
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                end
                ST_RDACK: begin
                    if (evt.rise) begin
                        if (!evt.sda) begin
                            word_addr <= word_addr + 1'b1;
                            state     <= ST_RDNEXT;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                ST_RDNEXT: begin
                    if (evt.fall) begin
                        tx      <= rdata;
                        sda_oe  <= ~rdata[7];
                        bit_cnt <= '0;
                        state   <= ST_RDBITS;
                    end
                end
                default: ;
            endcase
        end
    end

    // R8: reset always leaves the line released
    assert_reset_release_R8: assert property (@(posedge clk)
        rst |=> !sda_oe_o);

    // R4: an idle target never pulls the line
    assert_idle_released_R4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> !sda_oe_o);

    // R10: output only moves while SCL is low or on start/stop
    assert_hold_scl_high_R10: assert property (@(posedge clk) disable iff (rst)
        (evt.scl && !evt.start && !evt.stop) |=> $stable(sda_oe_o));

    // R5: the write cycle only ever begins right after a stop
    assert_busy_after_stop_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(evt.stop));
endmodule

// File: tb/spd_i2c_target_bench.sv
module spd_i2c_target_bench;
    localparam int Q   = 10;
    localparam int WRC = 3000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] strap = 3'b101;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_oe;
    wire        sda_line = sda_m & ~sda_oe;

    always #5 clk = ~clk;

    spd_i2c_target #(.WR_CYCLES(WRC)) u_spd_i2c_target (
        .clk      (clk),
        .rst      (rst),
        .strap_i  (strap),
        .scl_i    (scl_m),
        .sda_i    (sda_line),
        .sda_oe_o (sda_oe)
    );

    typedef struct {
        string      tag;
        logic [7:0] val;
    } item_t;

    item_t      exp_q[$];
    logic [7:0] act_q[$];
    int         vectors = 0;
    int         errors  = 0;
    bit         reported = 0;
    logic [7:0] model [256];
    item_t      mon_e;
    logic [7:0] mon_a;

    // R6 image computed from the requirement text
    function automatic logic [7:0] image_byte(int i);
        logic [7:0] s;
        if (i < 63) return 8'(7 * i + 3);
        if (i == 63) begin
            s = 0;
            for (int k = 0; k < 63; k++) s = s + 8'(7 * k + 3);
            return s;
        end
        if (i < 128) return 8'(i) ^ 8'hA5;
        return 8'hFF;
    endfunction

    task automatic expect_item(string tag, logic [7:0] v);
        exp_q.push_back('{tag, v});
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic i2c_start();
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic i2c_stop();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic send_bit(logic b);
        sda_m = b;    tick(Q);
        scl_m = 1'b1; tick(2 * Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic recv_bit(output logic b);
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        b = sda_line; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic send_byte(logic [7:0] v, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        recv_bit(b);
        ack = ~b;
    endtask

    task automatic recv_byte(logic give_ack, output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(b);
            v[i] = b;
        end
        send_bit(~give_ack);
    endtask

    // sends a byte and scores its acknowledge against the expectation
    task automatic byte_scored(string tag, logic [7:0] v, logic want_ack);
        logic ack;
        expect_item(tag, {7'd0, want_ack});
        send_byte(v, ack);
        act_q.push_back({7'd0, ack});
    endtask

    task automatic read_seq(string tag, logic [7:0] wa, int n);
        logic [7:0] v;
        i2c_start();
        byte_scored(tag, {4'b1010, strap, 1'b0}, 1'b1);
        byte_scored(tag, wa, 1'b1);
        i2c_start();
        byte_scored(tag, {4'b1010, strap, 1'b1}, 1'b1);
        for (int k = 0; k < n; k++) begin
            expect_item(tag, model[8'(wa + k)]);
            recv_byte(k < n - 1, v);
            act_q.push_back(v);
        end
        i2c_stop();
    endtask

    task automatic write_seq(string tag, logic [7:0] wa, int n, logic [7:0] base);
        i2c_start();
        byte_scored(tag, {4'b1010, strap, 1'b0}, 1'b1);
        byte_scored(tag, wa, 1'b1);
        for (int k = 0; k < n; k++) begin
            byte_scored(tag, 8'(base + 8'(k * 8'h11)), 1'b1);
            model[8'(wa + k)] = 8'(base + 8'(k * 8'h11));
        end
        i2c_stop();
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        end
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            wait (act_q.size() != 0);
            mon_a = act_q.pop_front();
            vectors++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL unexpected result: actual %02h expected none", mon_a);
            end else begin
                mon_e = exp_q.pop_front();
                if (mon_a !== mon_e.val) begin
                    errors++;
                    $display("FAIL %s: actual %02h expected %02h", mon_e.tag, mon_a, mon_e.val);
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected completion");
        report();
        $finish;
    end

    initial begin
        logic       b;
        logic [7:0] v;
        for (int i = 0; i < 256; i++) model[i] = image_byte(i);
        tick(5);
        rst = 1'b0;
        tick(3);

        // R8: line released after reset
        expect_item("R8", 8'd0);
        act_q.push_back({7'd0, sda_oe});

        // R1: wrong strap bits and wrong prefix are not acknowledged
        i2c_start();
        byte_scored("R1", {4'b1010, 3'b000, 1'b0}, 1'b0);
        i2c_stop();
        i2c_start();
        byte_scored("R1", {4'b1011, strap, 1'b1}, 1'b0);
        i2c_stop();

        // R6 / R3: default image, including checksum and region edges
        read_seq("R6", 8'd0, 64);
        read_seq("R6", 8'd124, 8);

        // R2 / R9: write across the top of the address space
        write_seq("R2", 8'hFE, 3, 8'h3C);

        // R5: address refused during the write cycle
        i2c_start();
        byte_scored("R5", {4'b1010, strap, 1'b0}, 1'b0);
        i2c_stop();
        tick(WRC + 200);

        // R9 / R3: read back across the wrap
        read_seq("R9", 8'hFD, 5);

        // R5: a word address alone starts no write cycle
        i2c_start();
        byte_scored("R5", {4'b1010, strap, 1'b0}, 1'b1);
        byte_scored("R5", 8'h20, 1'b1);
        i2c_stop();
        i2c_start();
        byte_scored("R5", {4'b1010, strap, 1'b1}, 1'b1);
        expect_item("R5", model[8'h20]);
        recv_byte(1'b0, v);
        act_q.push_back(v);
        i2c_stop();

        // R7: partial data byte cut by a stop is discarded
        i2c_start();
        byte_scored("R7", {4'b1010, strap, 1'b0}, 1'b1);
        byte_scored("R7", 8'h30, 1'b1);
        for (int i = 0; i < 4; i++) send_bit(1'b1);
        i2c_stop();
        read_seq("R7", 8'h30, 1);

        // R4: NACK releases the line and keeps the word address
        read_seq("R4", 8'h40, 1);
        expect_item("R4", 8'd1);
        recv_bit(b);
        act_q.push_back({7'd0, b});
        i2c_stop();
        i2c_start();
        byte_scored("R4", {4'b1010, strap, 1'b1}, 1'b1);
        expect_item("R4", model[8'h40]);
        recv_byte(1'b0, v);
        act_q.push_back(v);
        i2c_stop();

        // R1: new strap value moves the device address
        strap = 3'b010;
        tick(4);
        i2c_start();
        byte_scored("R1", {4'b1010, 3'b101, 1'b0}, 1'b0);
        i2c_stop();
        read_seq("R1", 8'h05, 2);

        wait (act_q.size() == 0);
        tick(2);
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL scoreboard: actual %0d leftover expected 0", exp_q.size());
        end
        report();
        $finish;
    end
endmodule